// File: doc/BRIEF.md
# Modem Host Interrupt and Control Registers

This block is the host-side register file of a wireless modem data pump. A microprocessor reaches it over a small synchronous bus with an address, write data, a write strobe and a read strobe. It holds four byte-wide registers: a control word, an interrupt enable mask, a set of interrupt flags and a receive status word. It also drives one active-low interrupt request line. The receive and transmit datapaths are outside the block. They report to it only through single-cycle event pulses.

Two control bits act as initialisation commands. A receive-init write clears every receive flag and the whole receive status word, including the saturating sync-error count. A transmit-init write marks the transmit buffer as empty. If that flag is enabled, the interrupt line then requests data. The host can work in either of two ways. It can enable sources in the mask and service the interrupt line, or it can mask everything and poll the flag register.

Top module: `mdm_hostregs`

## Requirements
- R1: After synchronous reset, all four registers read as 0x00, `rdata` is 0x00 and `irq_n` is high.
- R2: The address map is 0 control, 1 interrupt mask, 2 flags, 3 status. Control and mask read back the byte last written. Control bit 3 is the continuation indicator and is stored like any other bit.
- R3: Writes to address 2 or address 3 change nothing that is readable.
- R4: A pulse on `rx_sync_ev`, `rx_dec_ev` or `rx_idle_ev` sets flag bit 2, 1 or 0 respectively. The same pulse also sets status bit 7, 6 or 5. A pulse on `rx_err_ev` sets status bit 4 and increments the sync-error count in status bits 3:0. The count saturates at 15.
- R5: A read of the flags address returns the flags as they stood before the read, then clears flag bits 2:0. If a receive event arrives in the same cycle as that read, its flag stays set. A read never clears flag bit 4.
- R6: Writing control with bit 5 set clears flag bits 2:0 and the whole status register. A receive event in the same cycle is discarded. Flag bit 4 is untouched.
- R7: Flag bit 4 (transmit buffer empty) is set by a control write with bit 4 set, or by a `tx_empty_ev` pulse. It is cleared by a `tx_load_ev` pulse. If a set and a clear arrive in the same cycle, the set wins.
- R8: `irq_n` is registered. One clock after any change, it is low exactly when the bitwise AND of flags and mask is nonzero. This holds whether the flags or the mask changed.
- R9: With the mask at zero, events still set the flags, and `irq_n` stays high.
- R10: `rdata` is loaded on a clock edge where `rd_en` is high. On all other edges it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W (2) | Register address |
| wdata | input | DATA_W (8) | Host write data |
| rdata | output | DATA_W (8) | Registered read data |
| rx_sync_ev | input | 1 | Receive sync found pulse |
| rx_dec_ev | input | 1 | Receive block decoded pulse |
| rx_idle_ev | input | 1 | Receive idle detected pulse |
| rx_err_ev | input | 1 | Receive sync error pulse |
| tx_empty_ev | input | 1 | Transmit output buffer emptied pulse |
| tx_load_ev | input | 1 | Host began loading a transmit block |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest cases to reach are the collisions. In these, a clear command and a set event land on the same clock edge: a flag read that meets a decode pulse, a receive init that meets a sync pulse, and a transmit load that meets a buffer-empty pulse. The stimulus tasks raise the strobe and the event pulse together, so both are seen on one edge. The following reads then show which side won. The saturating error count needs its own long run of more than fifteen error pulses before it reaches its ceiling.

// File: rtl/mdm_reg_pkg.sv
package mdm_reg_pkg;
  localparam int A_CTRL   = 0;
  localparam int A_MASK   = 1;
  localparam int A_FLAGS  = 2;
  localparam int A_STATUS = 3;

  localparam int CB_RXINIT = 5;
  localparam int CB_TXINIT = 4;
  localparam int CB_CONT   = 3;

  localparam int FB_TXF   = 4;
  localparam int FB_SYNC  = 2;
  localparam int FB_DEC   = 1;
  localparam int FB_IDLE  = 0;
  localparam int N_RXFLAG = 3;

  typedef enum logic [1:0] {
    RSEL_CTRL   = 2'd0,
    RSEL_MASK   = 2'd1,
    RSEL_FLAGS  = 2'd2,
    RSEL_STATUS = 2'd3
  } rsel_e;
endpackage

// File: rtl/mdm_ctrl_regs.sv
module mdm_ctrl_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              rx_init,
  output logic              tx_init
);
  import mdm_reg_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_mask) mask_q <= wdata;
    end
  end

  // init commands fire on the write itself, not on the stored level
  always_comb begin
    rx_init = wr_ctrl && wdata[CB_RXINIT];
    tx_init = wr_ctrl && wdata[CB_TXINIT];
  end

  // R2: a control write lands in the register one edge later
  a_r2_ctrl_written: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> ctrl_q == $past(wdata));
endmodule

// File: rtl/mdm_irq_unit.sv
module mdm_irq_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_flags,
  input  logic              rx_init,
  input  logic              tx_init,
  input  logic [2:0]        rx_ev,      // [2] sync, [1] dec, [0] idle
  input  logic              tx_empty,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] flags,
  output logic              irq_n
);
  import mdm_reg_pkg::*;

  logic [N_RXFLAG-1:0] rxf_q, rxf_nx;
  logic                txf_q, txf_nx;

  // per-bit receive flag: read clears, event sets, init overrides both
  generate
    for (genvar i = 0; i < N_RXFLAG; i++) begin : g_rxf
      always_comb begin
        rxf_nx[i] = rxf_q[i];
        if (rd_flags) rxf_nx[i] = 1'b0;
        if (rx_ev[i]) rxf_nx[i] = 1'b1;
        if (rx_init)  rxf_nx[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    txf_nx = txf_q;
    if (tx_load)             txf_nx = 1'b0;
    if (tx_init || tx_empty) txf_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxf_q <= '0;
      txf_q <= 1'b0;
    end else begin
      rxf_q <= rxf_nx;
      txf_q <= txf_nx;
    end
  end

  always_comb begin
    flags = '0;
    flags[FB_SYNC] = rxf_q[2];
    flags[FB_DEC]  = rxf_q[1];
    flags[FB_IDLE] = rxf_q[0];
    flags[FB_TXF]  = txf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(flags & mask);
  end

  // R8: interrupt line follows enabled flags one edge later
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_n == !(|($past(flags) & $past(mask))));
  // R6: receive init empties the receive flags
  a_r6_init_clears_flags: assert property (@(posedge clk) disable iff (rst)
    rx_init |=> flags[FB_SYNC:FB_IDLE] == '0);
  // R7: a transmit set request always leaves TXF high
  a_r7_txf_set: assert property (@(posedge clk) disable iff (rst)
    (tx_init || tx_empty) |=> flags[FB_TXF]);
  // R5: a read with no concurrent event leaves receive flags clear
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_flags && rx_ev == '0) |=> flags[FB_SYNC:FB_IDLE] == '0);
endmodule

// File: rtl/mdm_rx_status.sv
module mdm_rx_status #(
  parameter int DATA_W = 8,
  parameter int SERR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_init,
  input  logic              ev_sync,
  input  logic              ev_dec,
  input  logic              ev_idle,
  input  logic              ev_err,
  output logic [DATA_W-1:0] status
);
  localparam logic [SERR_W-1:0] CNT_MAX = '1;

  logic              st_sync, st_dec, st_idle, st_err;
  logic [SERR_W-1:0] serr_cnt;

  always_ff @(posedge clk) begin
    if (rst || rx_init) begin
      st_sync  <= 1'b0;
      st_dec   <= 1'b0;
      st_idle  <= 1'b0;
      st_err   <= 1'b0;
      serr_cnt <= '0;
    end else begin
      if (ev_sync) st_sync <= 1'b1;
      if (ev_dec)  st_dec  <= 1'b1;
      if (ev_idle) st_idle <= 1'b1;
      if (ev_err) begin
        st_err <= 1'b1;
        if (serr_cnt != CNT_MAX) serr_cnt <= serr_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    status = '0;
    status[DATA_W-1] = st_sync;
    status[DATA_W-2] = st_dec;
    status[DATA_W-3] = st_idle;
    status[DATA_W-4] = st_err;
    status[SERR_W-1:0] = serr_cnt;
  end

  // R6: receive init wipes status
  a_r6_status_cleared: assert property (@(posedge clk) disable iff (rst)
    rx_init |=> status == '0);
  // R4: the error count never moves down except through init
  a_r4_count_monotone: assert property (@(posedge clk) disable iff (rst)
    !rx_init |=> serr_cnt >= $past(serr_cnt));
endmodule

// File: rtl/mdm_hostregs.sv
module mdm_hostregs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int SERR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rx_sync_ev,
  input  logic              rx_dec_ev,
  input  logic              rx_idle_ev,
  input  logic              rx_err_ev,
  input  logic              tx_empty_ev,
  input  logic              tx_load_ev,
  output logic              irq_n
);
  import mdm_reg_pkg::*;

  localparam logic [ADDR_W-1:0] LA_CTRL   = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] LA_MASK   = ADDR_W'(A_MASK);
  localparam logic [ADDR_W-1:0] LA_FLAGS  = ADDR_W'(A_FLAGS);
  localparam logic [ADDR_W-1:0] LA_STATUS = ADDR_W'(A_STATUS);

  logic [DATA_W-1:0] ctrl_q, mask_q, flags, status;
  logic              rx_init, tx_init;
  logic              wr_ctrl, wr_mask, rd_flags;

  assign wr_ctrl  = wr_en && addr == LA_CTRL;
  assign wr_mask  = wr_en && addr == LA_MASK;
  assign rd_flags = rd_en && addr == LA_FLAGS;

  mdm_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask),
    .wdata(wdata), .ctrl_q(ctrl_q), .mask_q(mask_q),
    .rx_init(rx_init), .tx_init(tx_init)
  );

  mdm_irq_unit #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .rd_flags(rd_flags), .rx_init(rx_init),
    .tx_init(tx_init), .rx_ev({rx_sync_ev, rx_dec_ev, rx_idle_ev}),
    .tx_empty(tx_empty_ev), .tx_load(tx_load_ev), .mask(mask_q),
    .flags(flags), .irq_n(irq_n)
  );

  mdm_rx_status #(.DATA_W(DATA_W), .SERR_W(SERR_W)) u_stat (
    .clk(clk), .rst(rst), .rx_init(rx_init), .ev_sync(rx_sync_ev),
    .ev_dec(rx_dec_ev), .ev_idle(rx_idle_ev), .ev_err(rx_err_ev),
    .status(status)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (addr)
      LA_CTRL:   rd_mux = ctrl_q;
      LA_MASK:   rd_mux = mask_q;
      LA_FLAGS:  rd_mux = flags;
      LA_STATUS: rd_mux = status;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R10: read data is stable without a read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R5: a flag read reports pre-clear contents
  a_r5_read_value: assert property (@(posedge clk) disable iff (rst)
    rd_flags |=> rdata == $past(flags));
endmodule

// File: tb/mdm_hostregs_tb.sv
module mdm_hostregs_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ev_sync = 0, ev_dec = 0, ev_idle = 0, ev_err = 0;
  logic       ev_txe = 0, ev_txl = 0;
  logic       irq_n;

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  mdm_hostregs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_sync_ev(ev_sync), .rx_dec_ev(ev_dec),
    .rx_idle_ev(ev_idle), .rx_err_ev(ev_err), .tx_empty_ev(ev_txe),
    .tx_load_ev(ev_txl), .irq_n(irq_n)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: issue a read and push the expected data
  task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic s, logic d, logic i, logic e, logic te, logic tl);
    ev_sync = s; ev_dec = d; ev_idle = i; ev_err = e; ev_txe = te; ev_txl = tl;
    @(negedge clk);
    {ev_sync, ev_dec, ev_idle, ev_err, ev_txe, ev_txl} = '0;
  endtask

  task automatic chk_irq(logic exp, string req);
    @(negedge clk);               // irq_n trails the flags by one edge
    check(req, {7'd0, irq_n}, {7'd0, exp});
  endtask

  // monitor: pop an expected item for each read strobe seen at an edge
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en && !rst) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("SB", 8'hEE, 8'h00);
        else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {7'd0, irq_n}, 8'h01);
    check("R1 rdata", rdata, 8'h00);
    rd(0, 8'h00, "R1 ctrl"); rd(1, 8'h00, "R1 mask");
    rd(2, 8'h00, "R1 flags"); rd(3, 8'h00, "R1 status");
    // R2 map and readback, CI bit stored
    wr(0, 8'h08); rd(0, 8'h08, "R2 ctrl CI");
    wr(1, 8'h17); rd(1, 8'h17, "R2 mask");
    // R3 read-only addresses
    wr(2, 8'hFF); wr(3, 8'hFF);
    rd(2, 8'h00, "R3 flags"); rd(3, 8'h00, "R3 status");
    chk_irq(1'b1, "R3 irq");
    // R4/R8 sync event
    pulse(1, 0, 0, 0, 0, 0);
    chk_irq(1'b0, "R8 irq low");
    rd(3, 8'h80, "R4 status sync");
    rd(2, 8'h04, "R5 flags before clear");
    chk_irq(1'b1, "R8 irq high after clear");
    rd(2, 8'h00, "R5 flags cleared");
    // R4 remaining events and saturation
    pulse(0, 1, 1, 1, 0, 0);
    rd(3, 8'hF1, "R4 status all");
    for (int k = 0; k < 20; k++) pulse(0, 0, 0, 1, 0, 0);
    rd(3, 8'hFF, "R4 count saturated");
    // R5 read colliding with decode event
    addr = 2; rd_en = 1'b1; ev_dec = 1'b1;
    exp_q.push_back(8'h03); tag_q.push_back("R5 collide value");
    @(negedge clk); rd_en = 1'b0; ev_dec = 1'b0;
    rd(2, 8'h02, "R5 event survives read");
    // R7 transmit init; read does not clear TXF
    wr(0, 8'h10);
    chk_irq(1'b0, "R7 irq on txf");
    rd(2, 8'h10, "R7 txf set");
    rd(2, 8'h10, "R5 txf kept by read");
    // R6 receive init colliding with sync event
    pulse(0, 0, 1, 0, 0, 0);
    addr = 0; wdata = 8'h20; wr_en = 1'b1; ev_sync = 1'b1;
    @(negedge clk); wr_en = 1'b0; ev_sync = 1'b0;
    rd(3, 8'h00, "R6 status cleared");
    rd(2, 8'h10, "R6 rx flags cleared, txf kept");
    rd(0, 8'h20, "R2 ctrl after init");
    // R7 load clears, set wins over clear
    pulse(0, 0, 0, 0, 0, 1);
    rd(2, 8'h00, "R7 load clears txf");
    chk_irq(1'b1, "R8 irq released");
    pulse(0, 0, 0, 0, 1, 1);
    rd(2, 8'h10, "R7 set wins");
    pulse(0, 0, 0, 0, 0, 1);
    rd(2, 8'h00, "R7 cleared again");
    // R9 polling with mask zero
    wr(1, 8'h00);
    pulse(1, 0, 0, 0, 0, 0);
    chk_irq(1'b1, "R9 masked irq");
    // R8 mask change alone asserts irq
    wr(1, 8'h04);
    chk_irq(1'b0, "R8 mask enables pending");
    rd(2, 8'h04, "R9 flag seen by poll");
    // R10 hold without read strobe
    pulse(0, 1, 0, 0, 0, 0);
    idle(2);
    check("R10 rdata held", rdata, 8'h04);
    idle(2);
    check("SB drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule